// File: doc/BRIEF.md
# Serial-Loaded Four-Channel Low-Side Driver Controller

This block is the digital core of a four-channel low-side switch controller. A host shifts one control bit per channel into a small shift register using a serial clock and data line. The bit that falls out of the far end of the register goes to a serial output, so several controllers can share one host port in a chain. A strobe input copies the register into a set of output latches. Each latched bit then drives one open-drain switch control, but only while the strobe is high and the active-low enable is low.

Overcurrent and undervoltage come from analog comparators as digital inputs that are already synchronous to the system clock. An overcurrent event turns off every drive for a fixed number of system clocks and pulls the active-low fault output low. If the overcurrent is still present when that interval ends, a new interval starts. If it has gone, the drives come back and the fault is released. Undervoltage and the active-high reset input both switch all drives off at once and hold every piece of internal state cleared while they are high.

The serial clock, serial data and strobe are asynchronous to the system clock. They pass through a synchronizer before the block detects their edges.

Top module: `serial_lsd_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, all state is cleared: `drive_on` is 0, `fault_n` is 1 and `ser_out` is 0.
- R2: Each rising edge of `ser_clk` shifts `ser_in` into channel 0 and moves every bit up one channel. After four edges, the first bit sent sits in channel 3 (most significant channel first). The shift takes effect SYNC_STAGES+1 clocks after the edge reaches the input.
- R3: On each falling edge of `ser_clk`, `ser_out` takes the value of the channel-3 register bit. This happens with the same SYNC_STAGES+1 clock delay.
- R4: A rising edge of `latch_in` copies the shift register into the output latches. While `latch_in` stays high, further shifting does not change the latches.
- R5: `drive_on[i]` is 1 only when latch bit i is 1, the latch control is high, `enable_n` is 0, no overcurrent interval is running and neither `uv_in` nor `reset_in` is high. `enable_n`, `uv_in` and `reset_in` switch the drives off in the same cycle.
- R6: Shifting and `ser_out` keep working while `enable_n` is high.
- R7: When `oc_in` is sampled high outside an interval, `drive_on` is 0 and `fault_n` is 0 from the next clock for RETRY_CYCLES clocks.
- R8: When an interval ends, one of two things happens. If `oc_in` is high at that moment, a new interval of RETRY_CYCLES starts. Otherwise `fault_n` returns to 1 and the drives are restored.
- R9: `reset_in` high clears the shift register, the output latches and any active fault at the next clock edge.
- R10: `uv_in` high holds all state cleared. After it drops, the drives stay off until new data is shifted in and latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_in | input | 1 | Serial data input |
| ser_out | output | 1 | Serial data output to the next device in the chain |
| latch_in | input | 1 | Latch strobe / latch control (asynchronous) |
| enable_n | input | 1 | Active-low output enable |
| reset_in | input | 1 | Active-high logic reset |
| oc_in | input | 1 | Overcurrent indication, synchronous to clk |
| uv_in | input | 1 | Undervoltage indication, synchronous to clk |
| drive_on | output | NCH | Per-channel open-drain switch control, 1 = on |
| fault_n | output | 1 | Active-low fault flag |

## Verification
An edge on `ser_clk` or `latch_in` that is driven just after clock edge k affects the register, `ser_out` or the latches after clock edge k+SYNC_STAGES+1, which is three edges with the default depth. `enable_n`, `uv_in` and `reset_in` mask the drives combinationally in the same cycle. An overcurrent sample at edge n pulls `fault_n` low after edge n and releases it after edge n+RETRY_CYCLES. The bench drives every input 1 ns after a rising edge. Its reference model keeps a per-input history that is SYNC_STAGES+2 samples deep and applies the same delays. `drive_on`, `ser_out` and `fault_n` are compared with the model on every falling edge, so each result is sampled in the cycle in which it is due.

// File: rtl/lsd_pkg.sv
// Shared types and helpers for the serial-loaded low-side driver controller.
package lsd_pkg;

    // State of the overcurrent retry sequencer.
    typedef enum logic {
        RT_IDLE  = 1'b0,
        RT_BLANK = 1'b1
    } retry_st_t;

    // Width needed to hold values 0 .. n-1 (at least one bit).
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/lsd_sync_edge.sv
// lsd_sync_edge: multi-bit synchronizer with edge detection.
// Each bit of async_in passes through STAGES flops. lvl is the synchronized
// level, prev is lvl one clock later, and rise/fall are single-cycle pulses
// formed from lvl and prev.
// Assumes each bit is an independent slow signal (no bus coherence needed)
// and that STAGES >= 2.
module lsd_sync_edge #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] prev,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);

    logic [STAGES-1:0][WIDTH-1:0] chain;
    logic [WIDTH-1:0]             prev_q;

    // Synchronizer chain: stage 0 samples the pins, each later stage follows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= async_in;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    // Delayed copy of the synchronized level, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= chain[STAGES-1];
        end
    end

    assign lvl  = chain[STAGES-1];
    assign prev = prev_q;

    // Per-bit edge pulses.
    for (genvar b = 0; b < WIDTH; b++) begin : g_edge
        assign rise[b] = lvl[b] & ~prev_q[b];
        assign fall[b] = ~lvl[b] & prev_q[b];
    end

    initial begin
        if (STAGES < 2) $error("lsd_sync_edge: STAGES must be at least 2");
    end

    // A rise pulse never lasts two cycles.
    p_single_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise[0] |=> !rise[0]);

endmodule

// File: rtl/lsd_shift.sv
// lsd_shift: serial-in shift register with a chain output.
// shift_en loads din into bit 0 and moves every bit up one place, so the
// first bit sent ends in the top channel. fall_en copies the top bit to sdo.
// Assumes shift_en and fall_en are single-cycle pulses that never coincide.
// clr holds everything at zero.
module lsd_shift #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           shift_en,
    input  logic           fall_en,
    input  logic           din,
    output logic [NCH-1:0] sr,
    output logic           sdo
);

    // Shift register update: clear has priority over a shift pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (clr) begin
            sr <= '0;
        end else if (shift_en) begin
            sr <= {sr[NCH-2:0], din};
        end
    end

    // Chain output follows the top bit on the serial clock's falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo <= 1'b0;
        end else if (clr) begin
            sdo <= 1'b0;
        end else if (fall_en) begin
            sdo <= sr[NCH-1];
        end
    end

    p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !clr) |=> (sr[0] == $past(din)));

    p_shift_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !clr) |=> (sr[NCH-1:1] == $past(sr[NCH-2:0])));

    p_sdo_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_en && !clr) |=> (sdo == $past(sr[NCH-1])));

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sr == '0 && !sdo));

endmodule

// File: rtl/lsd_out_latch.sv
// lsd_out_latch: output latches and the drive gating.
// cap loads the shift register into the latches. Between captures the
// latches hold. Each drive is its latch bit ANDed with the latch-control
// level and with the inverse of the enable, blank and kill inputs.
// Assumes cap is a single-cycle pulse. kill is a raw asynchronous-style
// mask that turns the drives off in the same cycle.
module lsd_out_latch #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           cap,
    input  logic           act,
    input  logic           en_n,
    input  logic           blank,
    input  logic           kill,
    input  logic [NCH-1:0] sr,
    output logic [NCH-1:0] drive
);

    logic [NCH-1:0] latch_q;
    logic           gate_ok;

    // Latch update: clear, then capture, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (clr) begin
            latch_q <= '0;
        end else if (cap) begin
            latch_q <= sr;
        end
    end

    // Shared gate term for all channels.
    assign gate_ok = act & ~en_n & ~blank & ~kill;

    // Per-channel open-drain control.
    for (genvar c = 0; c < NCH; c++) begin : g_drv
        assign drive[c] = latch_q[c] & gate_ok;
    end

    p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && !clr) |=> (latch_q == $past(sr)));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap && !clr) |=> (latch_q == $past(latch_q)));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (latch_q == '0));

endmodule

// File: rtl/lsd_retry.sv
// lsd_retry: overcurrent retry sequencer and fault flag.
// An oc sample while idle starts an interval of RETRY_CYCLES clocks. During
// the interval blank is high and the fault flag is set. At the end of the
// interval it restarts if oc is still high, otherwise it releases both.
// Assumes oc is synchronous to clk. clr aborts the sequence at once.
module lsd_retry
    import lsd_pkg::*;
#(
    parameter int RETRY_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic oc,
    output logic blank,
    output logic fault
);

    localparam int CW = cnt_width(RETRY_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(RETRY_CYCLES - 1);

    retry_st_t     state;
    logic [CW-1:0] cnt;
    logic          fault_q;
    logic          at_end;

    assign at_end = (cnt == '0);

    // Sequencer: idle until oc, then count down one interval, restart or release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RT_IDLE;
            cnt   <= '0;
        end else if (clr) begin
            state <= RT_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                RT_IDLE: begin
                    if (oc) begin
                        state <= RT_BLANK;
                        cnt   <= LAST;
                    end
                end
                RT_BLANK: begin
                    if (at_end) begin
                        if (oc) begin
                            cnt <= LAST;
                        end else begin
                            state <= RT_IDLE;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    state <= RT_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // Fault flag: set on a new event, dropped on release or clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
        end else if (clr) begin
            fault_q <= 1'b0;
        end else if (state == RT_IDLE && oc) begin
            fault_q <= 1'b1;
        end else if (state == RT_BLANK && at_end && !oc) begin
            fault_q <= 1'b0;
        end
    end

    assign blank = (state == RT_BLANK);
    assign fault = fault_q;

    p_oc_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (oc && !blank && !clr) |=> (blank && fault && cnt == LAST));

    p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (blank && !at_end && !clr) |=> (blank && fault && cnt == $past(cnt) - 1'b1));

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (blank && at_end && !oc && !clr) |=> (!blank && !fault));

    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (blank && at_end && oc && !clr) |=> (blank && fault && cnt == LAST));

    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!blank && !fault));

endmodule

// File: rtl/serial_lsd_ctrl.sv
// serial_lsd_ctrl: top of the serial-loaded low-side driver controller.
// It synchronizes the serial clock, data and strobe, shifts data into the
// channel register, captures it into the output latches and gates the
// drives with the enable, the overcurrent retry sequencer and the
// undervoltage/reset clear.
// Assumes oc_in, uv_in, reset_in and enable_n are synchronous to clk.
// ser_clk, ser_in and latch_in may be asynchronous but change slowly
// compared with clk.
module serial_lsd_ctrl #(
    parameter int NCH          = 4,
    parameter int SYNC_STAGES  = 2,
    parameter int RETRY_CYCLES = 1000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_clk,
    input  logic           ser_in,
    output logic           ser_out,
    input  logic           latch_in,
    input  logic           enable_n,
    input  logic           reset_in,
    input  logic           oc_in,
    input  logic           uv_in,
    output logic [NCH-1:0] drive_on,
    output logic           fault_n
);

    localparam int NSYNC = 3;
    localparam int IX_CLK = 0;
    localparam int IX_DAT = 1;
    localparam int IX_LAT = 2;

    logic [NSYNC-1:0] s_lvl, s_prev, s_rise, s_fall;
    logic [NCH-1:0]   sr;
    logic             clr;
    logic             blank;
    logic             fault;
    logic             sync_unused;

    // Undervoltage and reset share one clear path.
    assign clr = uv_in | reset_in;

    lsd_sync_edge #(
        .WIDTH  (NSYNC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({latch_in, ser_in, ser_clk}),
        .lvl      (s_lvl),
        .prev     (s_prev),
        .rise     (s_rise),
        .fall     (s_fall)
    );

    lsd_shift #(
        .NCH (NCH)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .shift_en (s_rise[IX_CLK]),
        .fall_en  (s_fall[IX_CLK]),
        .din      (s_lvl[IX_DAT]),
        .sr       (sr),
        .sdo      (ser_out)
    );

    lsd_out_latch #(
        .NCH (NCH)
    ) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .cap   (s_rise[IX_LAT]),
        .act   (s_prev[IX_LAT]),
        .en_n  (enable_n),
        .blank (blank),
        .kill  (clr),
        .sr    (sr),
        .drive (drive_on)
    );

    lsd_retry #(
        .RETRY_CYCLES (RETRY_CYCLES)
    ) u_retry (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .oc    (oc_in),
        .blank (blank),
        .fault (fault)
    );

    assign fault_n = ~fault;

    // Sync outputs that the datapath does not use.
    assign sync_unused = ^{s_lvl[IX_CLK], s_lvl[IX_LAT], s_prev[IX_DAT:IX_CLK],
                           s_rise[IX_DAT], s_fall[IX_LAT:IX_DAT]};

    p_masked_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_n || uv_in || reset_in || !fault_n) |-> (drive_on == '0));

    p_uv_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
        uv_in |=> fault_n);

endmodule

// File: tb/sim_serial_lsd_ctrl.sv
// Bench for serial_lsd_ctrl. A behavioural reference model with per-input
// sample histories is compared with the outputs on every falling clock edge.
module sim_serial_lsd_ctrl;

    localparam int NCH   = 4;
    localparam int SYNC  = 2;
    localparam int RETRY = 12;
    localparam int HALF  = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ser_clk = 1'b0;
    logic           ser_in = 1'b0;
    logic           latch_in = 1'b0;
    logic           enable_n = 1'b1;
    logic           reset_in = 1'b0;
    logic           oc_in = 1'b0;
    logic           uv_in = 1'b0;
    logic           ser_out;
    logic [NCH-1:0] drive_on;
    logic           fault_n;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    string phase  = "R1";

    always #5 clk = ~clk;

    serial_lsd_ctrl #(
        .NCH          (NCH),
        .SYNC_STAGES  (SYNC),
        .RETRY_CYCLES (RETRY)
    ) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .ser_in   (ser_in),
        .ser_out  (ser_out),
        .latch_in (latch_in),
        .enable_n (enable_n),
        .reset_in (reset_in),
        .oc_in    (oc_in),
        .uv_in    (uv_in),
        .drive_on (drive_on),
        .fault_n  (fault_n)
    );

    // Reference model state. h_*[k] holds the input sampled k edges ago.
    bit [SYNC+1:0] h_clk, h_dat, h_lat;
    bit [NCH-1:0]  m_sr, m_lq, m_old;
    bit            m_sdo, m_act, m_blank;
    int            m_cnt;

    // Model update at each rising edge, using the inputs as they were before it.
    always @(posedge clk) begin
        if (!rst_n) begin
            h_clk = '0; h_dat = '0; h_lat = '0;
            m_sr = '0; m_lq = '0; m_sdo = 1'b0; m_act = 1'b0;
            m_blank = 1'b0; m_cnt = 0;
        end else begin
            h_clk = {h_clk[SYNC:0], ser_clk};
            h_dat = {h_dat[SYNC:0], ser_in};
            h_lat = {h_lat[SYNC:0], latch_in};
            m_act = h_lat[SYNC];
            if (uv_in || reset_in) begin
                m_sr = '0; m_lq = '0; m_sdo = 1'b0;
                m_blank = 1'b0; m_cnt = 0;
            end else begin
                m_old = m_sr;
                if (h_clk[SYNC] && !h_clk[SYNC+1]) m_sr = {m_old[NCH-2:0], h_dat[SYNC]};
                if (!h_clk[SYNC] && h_clk[SYNC+1]) m_sdo = m_old[NCH-1];
                if (h_lat[SYNC] && !h_lat[SYNC+1]) m_lq = m_old;
                if (!m_blank) begin
                    if (oc_in) begin
                        m_blank = 1'b1;
                        m_cnt = RETRY;
                    end
                end else begin
                    m_cnt = m_cnt - 1;
                    if (m_cnt == 0) begin
                        if (oc_in) m_cnt = RETRY;
                        else m_blank = 1'b0;
                    end
                end
            end
        end
    end

    // Compare the outputs with the model halfway through each cycle.
    always @(negedge clk) begin
        if (!done) begin
            logic [NCH-1:0] exp_drv;
            exp_drv = (!enable_n && !m_blank && !uv_in && !reset_in && m_act) ? m_lq : '0;
            checks++;
            if (drive_on !== exp_drv) begin
                errors++;
                $display("FAIL %s drive_on: actual %b expected %b at %0t", phase, drive_on, exp_drv, $time);
            end
            checks++;
            if (ser_out !== m_sdo) begin
                errors++;
                $display("FAIL %s ser_out: actual %b expected %b at %0t", phase, ser_out, m_sdo, $time);
            end
            checks++;
            if (fault_n !== !m_blank) begin
                errors++;
                $display("FAIL %s fault_n: actual %b expected %b at %0t", phase, fault_n, !m_blank, $time);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_bit(input logic b);
        ser_in = b;
        tick(HALF);
        ser_clk = 1'b1;
        tick(HALF);
        ser_clk = 1'b0;
        tick(HALF);
    endtask

    // Most significant channel first.
    task automatic load(input logic [NCH-1:0] w);
        for (int i = NCH - 1; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic strobe_up();
        latch_in = 1'b1;
        tick(HALF + 2);
    endtask

    task automatic strobe_down();
        latch_in = 1'b0;
        tick(HALF);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired at %0t", $time);
        finish_run();
    end

    initial begin
        // R1: reset state while inputs are busy.
        phase = "R1";
        ser_in = 1'b1; latch_in = 1'b1; enable_n = 1'b0;
        tick(6);
        rst_n = 1'b1; latch_in = 1'b0; ser_in = 1'b0;
        tick(6);

        // R2, R5: load, latch and enable.
        phase = "R2";
        load(4'b1010);
        phase = "R5";
        strobe_up();
        tick(4);

        // R4: shifting while the latch is held leaves the drives alone.
        phase = "R4";
        load(4'b0101);
        tick(4);
        phase = "R5";
        strobe_down();
        phase = "R4";
        strobe_up();
        tick(4);

        // R6: shifting with the enable off, then enable.
        phase = "R6";
        enable_n = 1'b1;
        strobe_down();
        load(4'b1100);
        strobe_up();
        tick(3);
        enable_n = 1'b0;
        tick(4);

        // R3: chained output emits the earlier bits.
        phase = "R3";
        load(4'b0110);
        load(4'b1001);
        tick(4);

        // R7: single-cycle overcurrent.
        phase = "R7";
        strobe_down();
        load(4'b1111);
        strobe_up();
        oc_in = 1'b1;
        tick(1);
        oc_in = 1'b0;
        tick(RETRY + 4);

        // R8: overcurrent still present at the end of the interval.
        phase = "R8";
        oc_in = 1'b1;
        tick(RETRY + RETRY / 2);
        oc_in = 1'b0;
        tick(2 * RETRY + 4);

        // R9: reset during an interval clears fault and latches.
        phase = "R9";
        oc_in = 1'b1;
        tick(1);
        oc_in = 1'b0;
        tick(3);
        reset_in = 1'b1;
        tick(3);
        reset_in = 1'b0;
        tick(4);
        strobe_down();
        load(4'b0011);
        strobe_up();
        tick(4);

        // R10: undervoltage clears everything; reload required.
        phase = "R10";
        uv_in = 1'b1;
        tick(5);
        uv_in = 1'b0;
        tick(6);
        strobe_down();
        load(4'b1001);
        strobe_up();
        tick(6);

        finish_run();
    end

endmodule